// File: doc/BRIEF.md
# Control OUT Endpoint Zero Handshake Controller

This block keeps the control register of a USB device's control OUT endpoint zero and chooses the handshake (ACK, NAK or STALL) returned for each packet the packet engine reports. Software programs it through a simple register write port and reads it back through a read port. The packet engine drives single-cycle strobes: a SETUP packet arrived, an OUT data packet arrived, the transfer completed, or the endpoint was disabled. The block answers each SETUP or OUT strobe with a registered handshake code one clock later.

The hardware changes the register on its own when these events occur. A SETUP or a completion sets the internal NAK flag. A SETUP clears the STALL bit. Any of the three interrupt-causing events clears the enable bit. The matching interrupt pulse follows one clock after the enable bit drops. The enable bit is also given to the data mover as its go signal. A snoop bit forces the data mover's correctness-pass input true.

Top module: `ep0_out_ctrl`

## Requirements
- R1: After reset, rd_data is 0, and mover_en, chk_force, hs_valid and all three interrupt outputs are 0.
- R2: Writing a word with bit 31 = 1 sets the enable bit (rd_data[31], mirrored on mover_en). Writing 0 to bit 31 leaves it unchanged.
- R3: A strobe on ev_setup, ev_xfer_done or ev_ep_off clears the enable bit at the next clock edge. This clear wins over a software set in the same cycle.
- R4: Each of irq_setup, irq_xfer_done and irq_ep_off is a one-cycle pulse. It rises one clock after the enable bit has cleared, which is two clock edges after its event strobe.
- R5: Writing 1 to bit 27 sets the NAK flag and writing 1 to bit 26 clears it. If one write carries both, the set wins. Both bits always read as 0.
- R6: ev_setup and ev_xfer_done set the NAK flag. A hardware set wins over a software clear in the same cycle.
- R7: Writing 1 to bit 21 sets STALL (read back on rd_data[21]), and writing 0 to it has no effect. ev_setup clears STALL, and this clear wins over a software set in the same cycle.
- R8: One clock after ev_out, hs_valid is 1 and hs_code gives the handshake, encoded as 0 = ACK, 1 = NAK, 2 = STALL. The code is STALL if STALL is set. Otherwise it is NAK if the NAK flag or glb_out_nak is set. Otherwise it is ACK if the endpoint is enabled, and NAK if it is not.
- R9: One clock after ev_setup, hs_valid is 1 and hs_code is ACK, whatever the STALL, NAK, global NAK and enable state. If ev_setup and ev_out arrive together, the SETUP answer is given.
- R10: Bit 20 is a read/write snoop bit. While it is 1, chk_force is 1.
- R11: Bits 30, 29:28, 25:22, 19:18 and 17:0 always read as 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read view |
| glb_out_nak | input | 1 | Device-wide OUT NAK request |
| ev_setup | input | 1 | SETUP packet received strobe |
| ev_out | input | 1 | OUT data packet received strobe |
| ev_xfer_done | input | 1 | Transfer completed strobe |
| ev_ep_off | input | 1 | Endpoint disabled event strobe |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| mover_en | output | 1 | Enable for the data mover |
| chk_force | output | 1 | Forces the mover's check-pass input true |
| irq_setup | output | 1 | SETUP phase done interrupt pulse |
| irq_ep_off | output | 1 | Endpoint disabled interrupt pulse |
| irq_xfer_done | output | 1 | Transfer completed interrupt pulse |

## Verification
The bench builds the block with its default REG_W of 32, which places every control bit at its fixed position and lets a single all-ones write exercise the fixed-zero fields together with the set-wins NAK rule. At this width, the handshake priority can be driven through every combination of STALL, NAK, global NAK and enable. It also reaches the same-cycle collisions between software writes and hardware events.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  localparam int EN_BIT    = 31;
  localparam int SNAK_BIT  = 27;
  localparam int CNAK_BIT  = 26;
  localparam int STALL_BIT = 21;
  localparam int SNOOP_BIT = 20;
  localparam int N_IRQ     = 3;
endpackage

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ev_setup,
  input  logic             ev_done,
  input  logic             ev_off,
  output logic             en_q,
  output logic             nak_q,
  output logic             stall_q,
  output logic             snoop_q,
  output logic [REG_W-1:0] rd_data
);
  logic hw_clr_en;
  logic hw_set_nak;
  logic sw_set_nak;
  logic sw_clr_nak;

  assign hw_clr_en  = ev_setup | ev_done | ev_off;
  assign hw_set_nak = ev_setup | ev_done;
  assign sw_set_nak = wr_en & wr_data[SNAK_BIT];
  assign sw_clr_nak = wr_en & wr_data[CNAK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      nak_q   <= 1'b0;
      stall_q <= 1'b0;
      snoop_q <= 1'b0;
    end else begin
      if (hw_clr_en)                            en_q <= 1'b0;
      else if (wr_en && wr_data[EN_BIT])        en_q <= 1'b1;

      if (hw_set_nak || sw_set_nak)             nak_q <= 1'b1;
      else if (sw_clr_nak)                      nak_q <= 1'b0;

      if (ev_setup)                             stall_q <= 1'b0;
      else if (wr_en && wr_data[STALL_BIT])     stall_q <= 1'b1;

      if (wr_en)                                snoop_q <= wr_data[SNOOP_BIT];
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[EN_BIT]    = en_q;
    rd_data[STALL_BIT] = stall_q;
    rd_data[SNOOP_BIT] = snoop_q;
  end
endmodule

// File: rtl/ep0_resp.sv
module ep0_resp
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_setup,
  input  logic       ev_out,
  input  logic       en,
  input  logic       nak,
  input  logic       stall,
  input  logic       glb_nak,
  output logic       hs_valid,
  output logic [1:0] hs_code
);
  hs_e next_code;

  always_comb begin
    if (ev_setup)            next_code = HS_ACK;
    else if (stall)          next_code = HS_STALL;
    else if (nak || glb_nak) next_code = HS_NAK;
    else if (en)             next_code = HS_ACK;
    else                     next_code = HS_NAK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= ev_setup | ev_out;
      hs_code  <= (ev_setup | ev_out) ? next_code : HS_ACK;
    end
  end
endmodule

// File: rtl/ep0_irq.sv
module ep0_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  output logic [N-1:0] irq
);
  for (genvar g = 0; g < N; g++) begin : g_chan
    logic seen_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q <= 1'b0;
        irq[g] <= 1'b0;
      end else begin
        seen_q <= ev[g];
        irq[g] <= seen_q;
      end
    end
  end
endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl
  import ep0_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             glb_out_nak,
  input  logic             ev_setup,
  input  logic             ev_out,
  input  logic             ev_xfer_done,
  input  logic             ev_ep_off,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             mover_en,
  output logic             chk_force,
  output logic             irq_setup,
  output logic             irq_ep_off,
  output logic             irq_xfer_done
);
  logic             en_w;
  logic             nak_w;
  logic             stall_w;
  logic             snoop_w;
  logic [N_IRQ-1:0] irq_w;

  ep0_csr #(.REG_W(REG_W)) u_csr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ev_setup (ev_setup),
    .ev_done  (ev_xfer_done),
    .ev_off   (ev_ep_off),
    .en_q     (en_w),
    .nak_q    (nak_w),
    .stall_q  (stall_w),
    .snoop_q  (snoop_w),
    .rd_data  (rd_data)
  );

  ep0_resp u_resp (
    .clk      (clk),
    .rst      (rst),
    .ev_setup (ev_setup),
    .ev_out   (ev_out),
    .en       (en_w),
    .nak      (nak_w),
    .stall    (stall_w),
    .glb_nak  (glb_out_nak),
    .hs_valid (hs_valid),
    .hs_code  (hs_code)
  );

  ep0_irq #(.N(N_IRQ)) u_irq (
    .clk (clk),
    .rst (rst),
    .ev  ({ev_ep_off, ev_xfer_done, ev_setup}),
    .irq (irq_w)
  );

  assign irq_setup     = irq_w[0];
  assign irq_xfer_done = irq_w[1];
  assign irq_ep_off    = irq_w[2];
  assign mover_en      = en_w;
  assign chk_force     = snoop_w;
endmodule

// File: rtl/ep0_out_ctrl_chk.sv
module ep0_out_ctrl_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rd_data,
  input logic             ev_setup,
  input logic             ev_out,
  input logic             ev_xfer_done,
  input logic             hs_valid,
  input logic [1:0]       hs_code,
  input logic             mover_en,
  input logic             irq_setup,
  input logic             irq_xfer_done
);
  // R3
  setup_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> !mover_en);
  // R4
  irq_after_en_low_chk: assert property (@(posedge clk) disable iff (rst)
    irq_setup |-> !$past(mover_en));
  // R4
  done_irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_xfer_done) |-> $past(ev_xfer_done, 2));
  // R9
  setup_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (hs_valid && hs_code == 2'd0));
  // R8
  stall_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_out && !ev_setup && rd_data[21]) |=> (hs_valid && hs_code == 2'd2));
  // R7
  setup_unstall_chk: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> !rd_data[21]);
  // R11
  fixed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[30:22] == '0) && (rd_data[19:0] == '0));
endmodule

bind ep0_out_ctrl ep0_out_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rd_data       (rd_data),
  .ev_setup      (ev_setup),
  .ev_out        (ev_out),
  .ev_xfer_done  (ev_xfer_done),
  .hs_valid      (hs_valid),
  .hs_code       (hs_code),
  .mover_en      (mover_en),
  .irq_setup     (irq_setup),
  .irq_xfer_done (irq_xfer_done)
);

// File: tb/test_ep0_out_ctrl.sv
module test_ep0_out_ctrl;
  localparam int REG_W  = 32;
  localparam time PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic             glb_out_nak = 1'b0;
  logic             ev_setup = 1'b0;
  logic             ev_out = 1'b0;
  logic             ev_xfer_done = 1'b0;
  logic             ev_ep_off = 1'b0;
  logic             hs_valid;
  logic [1:0]       hs_code;
  logic             mover_en;
  logic             chk_force;
  logic             irq_setup;
  logic             irq_ep_off;
  logic             irq_xfer_done;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  ep0_out_ctrl #(.REG_W(REG_W)) i_ep0_out_ctrl (
    .clk, .rst, .wr_en, .wr_data, .rd_data, .glb_out_nak,
    .ev_setup, .ev_out, .ev_xfer_done, .ev_ep_off,
    .hs_valid, .hs_code, .mover_en, .chk_force,
    .irq_setup, .irq_ep_off, .irq_xfer_done
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected handshake codes as they appear
  always @(negedge clk) begin
    if (!rst && hs_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected handshake", 32'(hs_code), 32'hFF);
      else check("R8/R9 handshake", 32'(hs_code), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pkt_out(logic [1:0] exp);
    @(negedge clk);
    ev_out = 1'b1; exp_q.push_back(exp);
    @(negedge clk);
    ev_out = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    check("R8 queue drained", 32'(exp_q.size()), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 rd_data", rd_data, 0);
    check("R1 outputs", {mover_en, chk_force, hs_valid, irq_setup, irq_ep_off, irq_xfer_done}, 0);

    // R2
    wr(32'h8000_0000);
    check("R2 enable set", {rd_data[31], mover_en}, 2'b11);
    wr(32'h0);
    check("R2 zero write keeps enable", 32'(mover_en), 1);

    // R8 enabled, no NAK -> ACK
    pkt_out(2'd0);
    // R5 set NAK, reads 0
    wr(32'h0800_0000);
    check("R5 set-NAK reads zero", 32'(rd_data[27:26]), 0);
    pkt_out(2'd1);
    wr(32'h0400_0000);
    pkt_out(2'd0);
    wr(32'h0C00_0000); // R5 both bits: set wins
    pkt_out(2'd1);
    wr(32'h0400_0000);
    // R8 global NAK
    glb_out_nak = 1'b1;
    pkt_out(2'd1);
    // R7 stall set, outranks NAK and global NAK
    wr(32'h0820_0000);
    check("R7 stall reads back", 32'(rd_data[21]), 1);
    pkt_out(2'd2);
    glb_out_nak = 1'b0;
    wr(32'h0);
    check("R7 zero write keeps stall", 32'(rd_data[21]), 1);
    drain();

    // R9 SETUP always ACK, then R3/R4/R6/R7 side effects
    @(negedge clk);
    ev_setup = 1'b1; exp_q.push_back(2'd0);
    wr_en = 1'b1; wr_data = 32'h0020_0000; // R7 set loses to SETUP clear
    @(negedge clk);
    ev_setup = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R3 setup clears enable", 32'(mover_en), 0);
    check("R7 setup clears stall", 32'(rd_data[21]), 0);
    check("R4 no irq while enable just cleared", 32'(irq_setup), 0);
    @(negedge clk);
    check("R4 irq_setup pulse", {irq_setup, irq_xfer_done, irq_ep_off}, 3'b100);
    @(negedge clk);
    check("R4 irq_setup one cycle", 32'(irq_setup), 0);
    wr(32'h8000_0000);
    pkt_out(2'd1); // R6 setup left NAK set

    // R6 completion sets NAK, wins over same-cycle clear
    wr(32'h0400_0000);
    pkt_out(2'd0);
    @(negedge clk);
    ev_xfer_done = 1'b1; wr_en = 1'b1; wr_data = 32'h0400_0000;
    @(negedge clk);
    ev_xfer_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R3 done clears enable", 32'(mover_en), 0);
    @(negedge clk);
    check("R4 irq_xfer_done pulse", {irq_setup, irq_xfer_done, irq_ep_off}, 3'b010);
    wr(32'h8000_0000);
    pkt_out(2'd1); // R6 NAK survived clear

    // R3 endpoint-off clear wins over set
    @(negedge clk);
    ev_ep_off = 1'b1; wr_en = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk);
    ev_ep_off = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R3 clear beats set", {rd_data[31], mover_en}, 2'b00);
    @(negedge clk);
    check("R4 irq_ep_off pulse", {irq_setup, irq_xfer_done, irq_ep_off}, 3'b001);

    // R8 not enabled, no NAK -> NAK
    wr(32'h0400_0000);
    pkt_out(2'd1);

    // R9 SETUP and OUT together: ACK, even under STALL
    wr(32'h0020_0000);
    @(negedge clk);
    ev_setup = 1'b1; ev_out = 1'b1; exp_q.push_back(2'd0);
    @(negedge clk);
    ev_setup = 1'b0; ev_out = 1'b0;
    drain();

    // R10 snoop
    wr(32'h0010_0000);
    check("R10 snoop set", {rd_data[20], chk_force}, 2'b11);
    wr(32'h0);
    check("R10 snoop clear", {rd_data[20], chk_force}, 2'b00);

    // R11 fixed fields, with R5 set-wins via all-ones write
    wr(32'hFFFF_FFFF);
    check("R11 all-ones readback", rd_data, 32'h8030_0000);
    pkt_out(2'd2);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule